// File: doc/BRIEF.md
# Dual-Width Binary/Decimal ALU

The block is the arithmetic and logic unit for register-format operations of a microcoded datapath. One 3-bit operation code selects OR, XOR, AND, binary add or subtract with carry, decimal (BCD) add or subtract with carry, or a nibble multiply. By default an operation works on one byte. With the extended flag set it works on a register pair as a single 16-bit operation. In that mode the carry enters the low byte only and then ripples into the high byte. Extended operations take the same number of cycles as byte operations.

A 2-bit carry control sets the carry that feeds the operation. It can pass the incoming carry through, or force it to 0 or to 1. Each operand has its own dummy select, which replaces that operand with zero. Alongside the result, the block gives unsigned less-than and less-or-equal flags for register-compare branches. These flags cover the active width, so in extended mode they compare all 16 bits.

All outputs are registered and appear one cycle after a qualified request. They hold their value while no request is present.

Top module: `dw_alu`

## Requirements
- R1: Operation code 000 gives A|B, 001 gives A^B and 010 gives A&B. For these three codes the carry output equals the effective carry.
- R2: The effective carry comes from carry control bits {1,0}. Code 10 forces it to 0 and 11 forces it to 1. Codes 00 and 01 use carry_i.
- R3: Code 110 gives A+B+c. The carry output is the carry out of the active width.
- R4: Code 011 gives A+~B+c, where c=1 means no borrow. The carry output is 1 exactly when no borrow occurs.
- R5: Code 100 is a BCD add of the operand digits plus c, one digit per 4-bit nibble. The carry output is 1 when the decimal sum overflows the active width.
- R6: Code 101 is a BCD subtract A-B-(1-c), one digit per nibble. The result wraps modulo 10^digits. The carry output is 1 when no decimal borrow occurs.
- R7: When ext_i is 0, the operation uses bits 7:0 only. Bits 15:8 of the operands are ignored and result bits 15:8 are 0. When ext_i is 1, the operation is a true 16-bit operation: the effective carry enters bit 0 only, and the carry output comes from bit 15.
- R8: Code 111 multiplies one 4-bit nibble of A bits 7:0 by one 4-bit nibble of B bits 7:0. A select of 1 picks bits 7:4 and 0 picks bits 3:0. The 8-bit product goes to result bits 7:0 and bits 15:8 are 0 in both widths. The carry output equals the effective carry.
- R9: An operand whose dummy select is 1 is taken as zero, both for the operation and for the compare flags.
- R10: lt_o is set when A < B and le_o when A <= B, as unsigned values over the active width (8 or 16 bits). This holds for every operation code.
- R11: Reset clears all outputs. valid_o follows valid_i one cycle later at both widths. The outputs hold their value in cycles after valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request qualifier |
| op_i | input | 3 | Operation code |
| ext_i | input | 1 | 1 selects the 16-bit pair operation |
| carry_ctl_i | input | 2 | Carry preset control |
| carry_i | input | 1 | Incoming carry |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| a_dummy_i | input | 1 | Replace A with zero |
| b_dummy_i | input | 1 | Replace B with zero |
| mul_hi_a_i | input | 1 | Multiply: 1 selects the high nibble of A |
| mul_hi_b_i | input | 1 | Multiply: 1 selects the high nibble of B |
| valid_o | output | 1 | Result valid |
| result_o | output | 16 | Result |
| carry_o | output | 1 | Carry out |
| lt_o | output | 1 | A < B over the active width |
| le_o | output | 1 | A <= B over the active width |

## Verification
The assertions assume that operation codes, widths and carry controls arrive only alongside valid_i, and that decimal operations are given valid BCD digits. Non-BCD nibbles in a decimal operation produce a defined but meaningless digit, and no property depends on them. The stimulus draws decimal operands digit by digit from 0 to 9. It uses the full byte and word range only for binary, logic and multiply codes. Idle gaps between requests exercise the hold behaviour.

// File: rtl/dw_alu_pkg.sv
package dw_alu_pkg;
  typedef enum logic [2:0] {
    OP_OR   = 3'b000,
    OP_XOR  = 3'b001,
    OP_AND  = 3'b010,
    OP_BSUB = 3'b011,
    OP_DADD = 3'b100,
    OP_DSUB = 3'b101,
    OP_BADD = 3'b110,
    OP_MUL  = 3'b111
  } alu_op_e;

  localparam int unsigned NIB_W = 4;
endpackage

// File: rtl/dw_alu_bcd_digit.sv
module dw_alu_bcd_digit (
  input  logic       sub_i,
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] sum_o,
  output logic       cout_o
);
  logic [4:0] raw;
  logic       adj;

  always_comb begin
    if (sub_i) begin
      // cin_i = 1 means no borrow pending
      raw    = {1'b0, a_i} - {1'b0, b_i} - {4'b0000, ~cin_i};
      adj    = raw[4];
      sum_o  = adj ? (raw[3:0] - 4'd6) : raw[3:0];
      cout_o = ~adj;
    end else begin
      raw    = {1'b0, a_i} + {1'b0, b_i} + {4'b0000, cin_i};
      adj    = (raw > 5'd9);
      sum_o  = adj ? (raw[3:0] + 4'd6) : raw[3:0];
      cout_o = adj;
    end
  end
endmodule

// File: rtl/dw_alu_slice.sv
module dw_alu_slice
  import dw_alu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              carry_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              carry_o
);
  localparam int unsigned NUM_NIB = BYTE_W / NIB_W;

  logic [BYTE_W-1:0] b_bin;
  logic [BYTE_W:0]   bin_sum;
  logic [NUM_NIB:0]  dec_c;
  logic [BYTE_W-1:0] dec_res;
  logic              dec_sub;

  assign b_bin   = (op_i == OP_BSUB) ? ~b_i : b_i;
  assign bin_sum = {1'b0, a_i} + {1'b0, b_bin} + {{BYTE_W{1'b0}}, carry_i};
  assign dec_sub = (op_i == OP_DSUB);
  assign dec_c[0] = carry_i;

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_digit
    dw_alu_bcd_digit u_digit (
      .sub_i  (dec_sub),
      .a_i    (a_i[g*NIB_W +: NIB_W]),
      .b_i    (b_i[g*NIB_W +: NIB_W]),
      .cin_i  (dec_c[g]),
      .sum_o  (dec_res[g*NIB_W +: NIB_W]),
      .cout_o (dec_c[g+1])
    );
  end

  always_comb begin
    res_o   = '0;
    carry_o = carry_i;
    unique case (op_i)
      OP_OR:           res_o = a_i | b_i;
      OP_XOR:          res_o = a_i ^ b_i;
      OP_AND:          res_o = a_i & b_i;
      OP_BADD, OP_BSUB: begin
        res_o   = bin_sum[BYTE_W-1:0];
        carry_o = bin_sum[BYTE_W];
      end
      OP_DADD, OP_DSUB: begin
        res_o   = dec_res;
        carry_o = dec_c[NUM_NIB];
      end
      default: ;  // multiply handled outside the slice
    endcase
  end
endmodule

// File: rtl/dw_alu_nib_mul.sv
module dw_alu_nib_mul
  import dw_alu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0]  a_i,
  input  logic [BYTE_W-1:0]  b_i,
  input  logic               hi_a_i,
  input  logic               hi_b_i,
  output logic [2*NIB_W-1:0] prod_o
);
  logic [NIB_W-1:0] na;
  logic [NIB_W-1:0] nb;

  assign na     = hi_a_i ? a_i[2*NIB_W-1:NIB_W] : a_i[NIB_W-1:0];
  assign nb     = hi_b_i ? b_i[2*NIB_W-1:NIB_W] : b_i[NIB_W-1:0];
  assign prod_o = {{NIB_W{1'b0}}, na} * {{NIB_W{1'b0}}, nb};
endmodule

// File: rtl/dw_alu_cmp.sv
module dw_alu_cmp #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] a_i,
  input  logic [2*BYTE_W-1:0] b_i,
  input  logic                wide_i,
  output logic                lt_o,
  output logic                le_o
);
  logic [2*BYTE_W-1:0] a_eff;
  logic [2*BYTE_W-1:0] b_eff;

  assign a_eff = wide_i ? a_i : {{BYTE_W{1'b0}}, a_i[BYTE_W-1:0]};
  assign b_eff = wide_i ? b_i : {{BYTE_W{1'b0}}, b_i[BYTE_W-1:0]};
  assign lt_o  = (a_eff < b_eff);
  assign le_o  = ~(b_eff < a_eff);
endmodule

// File: rtl/dw_alu.sv
module dw_alu
  import dw_alu_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic                ext_i,
  input  logic [1:0]          carry_ctl_i,
  input  logic                carry_i,
  input  logic [2*BYTE_W-1:0] a_i,
  input  logic [2*BYTE_W-1:0] b_i,
  input  logic                a_dummy_i,
  input  logic                b_dummy_i,
  input  logic                mul_hi_a_i,
  input  logic                mul_hi_b_i,
  output logic                valid_o,
  output logic [2*BYTE_W-1:0] result_o,
  output logic                carry_o,
  output logic                lt_o,
  output logic                le_o
);
  localparam int unsigned NUM_BYTES = 2;
  localparam int unsigned DATA_W    = NUM_BYTES * BYTE_W;

  alu_op_e                               op;
  logic [DATA_W-1:0]                     a_op;
  logic [DATA_W-1:0]                     b_op;
  logic                                  carry_eff;
  logic [NUM_BYTES:0]                    chain;
  logic [NUM_BYTES-1:0][BYTE_W-1:0]      s_res;
  logic [2*NIB_W-1:0]                    prod;
  logic [DATA_W-1:0]                     res_d;
  logic                                  carry_d;
  logic                                  lt_d;
  logic                                  le_d;

  assign op        = alu_op_e'(op_i);
  assign a_op      = a_dummy_i ? '0 : a_i;
  assign b_op      = b_dummy_i ? '0 : b_i;
  // preset applies once, before the lowest byte only
  assign carry_eff = carry_ctl_i[1] ? carry_ctl_i[0] : carry_i;
  assign chain[0]  = carry_eff;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    dw_alu_slice #(.BYTE_W(BYTE_W)) u_slice (
      .op_i    (op),
      .a_i     (a_op[i*BYTE_W +: BYTE_W]),
      .b_i     (b_op[i*BYTE_W +: BYTE_W]),
      .carry_i (chain[i]),
      .res_o   (s_res[i]),
      .carry_o (chain[i+1])
    );
  end

  dw_alu_nib_mul #(.BYTE_W(BYTE_W)) u_mul (
    .a_i    (a_op[BYTE_W-1:0]),
    .b_i    (b_op[BYTE_W-1:0]),
    .hi_a_i (mul_hi_a_i),
    .hi_b_i (mul_hi_b_i),
    .prod_o (prod)
  );

  dw_alu_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .a_i    (a_op),
    .b_i    (b_op),
    .wide_i (ext_i),
    .lt_o   (lt_d),
    .le_o   (le_d)
  );

  always_comb begin
    if (op == OP_MUL) begin
      res_d   = {{(DATA_W-2*NIB_W){1'b0}}, prod};
      carry_d = carry_eff;
    end else if (ext_i) begin
      res_d   = s_res;
      carry_d = chain[NUM_BYTES];
    end else begin
      res_d   = {{(DATA_W-BYTE_W){1'b0}}, s_res[0]};
      carry_d = chain[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
      lt_o     <= 1'b0;
      le_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        carry_o  <= carry_d;
        lt_o     <= lt_d;
        le_o     <= le_d;
      end
    end
  end
endmodule

// File: rtl/dw_alu_chk.sv
module dw_alu_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [2:0]          op_i,
  input logic                ext_i,
  input logic [1:0]          carry_ctl_i,
  input logic                a_dummy_i,
  input logic                b_dummy_i,
  input logic                valid_o,
  input logic [2*BYTE_W-1:0] result_o,
  input logic                carry_o,
  input logic                lt_o,
  input logic                le_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R11
  AST_IDLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o));  // R11
  AST_LT_IMPLIES_LE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lt_o |-> le_o);  // R10
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ext_i) |=> (result_o[2*BYTE_W-1:BYTE_W] == '0));  // R7
  AST_MUL_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'b111) |=> (result_o[2*BYTE_W-1:BYTE_W] == '0));  // R8
  AST_FORCED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'b010 && carry_ctl_i == 2'b10) |=> !carry_o);  // R2
  AST_FORCED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'b010 && carry_ctl_i == 2'b11) |=> carry_o);  // R2
  AST_DUMMY_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_dummy_i && b_dummy_i) |=> (le_o && !lt_o));  // R9
endmodule

bind dw_alu dw_alu_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .ext_i       (ext_i),
  .carry_ctl_i (carry_ctl_i),
  .a_dummy_i   (a_dummy_i),
  .b_dummy_i   (b_dummy_i),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .carry_o     (carry_o),
  .lt_o        (lt_o),
  .le_o        (le_o)
);

// File: tb/dw_alu_test.sv
`timescale 1ns/1ps
module dw_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic        ext = 1'b0;
  logic [1:0]  cctl = '0;
  logic        cin = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        adum = 1'b0;
  logic        bdum = 1'b0;
  logic        hia = 1'b0;
  logic        hib = 1'b0;
  logic        valid_o;
  logic [15:0] result_o;
  logic        carry_o;
  logic        lt_o;
  logic        le_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] res;
    logic        c;
    logic        lt;
    logic        le;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #5 clk = ~clk;

  dw_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .ext_i(ext),
    .carry_ctl_i(cctl), .carry_i(cin), .a_i(a), .b_i(b),
    .a_dummy_i(adum), .b_dummy_i(bdum), .mul_hi_a_i(hia), .mul_hi_b_i(hib),
    .valid_o(valid_o), .result_o(result_o), .carry_o(carry_o),
    .lt_o(lt_o), .le_o(le_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int bcd_val(input logic [15:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'((v >> (4 * i)) & 16'hF);
    return r;
  endfunction

  function automatic logic [15:0] to_bcd(input int v, input int nd);
    logic [15:0] r = '0;
    int t = v;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'b000, 3'b001, 3'b010: return "R1";
      3'b110: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R8";
    endcase
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(input logic [2:0] o, input logic x,
                                 input logic [1:0] cc, input logic ci,
                                 input logic [15:0] av_in, input logic [15:0] bv_in,
                                 input logic ad, input logic bd,
                                 input logic ha, input logic hb);
    exp_t e;
    int w = x ? 16 : 8;
    int m = 1 << w;
    int nd = w / 4;
    int pw = x ? 10000 : 100;
    int av = ad ? 0 : int'(av_in) % m;
    int bv = bd ? 0 : int'(bv_in) % m;
    int ce = (cc == 2'b10) ? 0 : (cc == 2'b11) ? 1 : int'(ci);
    int s;
    e.tag = "";
    case (o)
      3'b000: begin e.res = 16'(av | bv); e.c = ce[0]; end
      3'b001: begin e.res = 16'(av ^ bv); e.c = ce[0]; end
      3'b010: begin e.res = 16'(av & bv); e.c = ce[0]; end
      3'b110: begin s = av + bv + ce; e.res = 16'(s % m); e.c = (s >= m); end
      3'b011: begin s = av + (m - 1 - bv) + ce; e.res = 16'(s % m); e.c = (s >= m); end
      3'b100: begin
        s = bcd_val(16'(av), nd) + bcd_val(16'(bv), nd) + ce;
        e.c = (s >= pw);
        e.res = to_bcd(s % pw, nd);
      end
      3'b101: begin
        s = bcd_val(16'(av), nd) - bcd_val(16'(bv), nd) - (1 - ce);
        e.c = (s >= 0);
        if (s < 0) s += pw;
        e.res = to_bcd(s, nd);
      end
      default: begin
        s = ((ha ? (av >> 4) : av) & 15) * ((hb ? (bv >> 4) : bv) & 15);
        e.res = 16'(s);
        e.c = ce[0];
      end
    endcase
    e.lt = (av < bv);
    e.le = (av <= bv);
    return e;
  endfunction

  task automatic drive(input string tag, input logic [2:0] o, input logic x,
                       input logic [1:0] cc, input logic ci,
                       input logic [15:0] av, input logic [15:0] bv,
                       input logic ad = 1'b0, input logic bd = 1'b0,
                       input logic ha = 1'b0, input logic hb = 1'b0);
    exp_t e;
    @(negedge clk);
    op = o; ext = x; cctl = cc; cin = ci; a = av; b = bv;
    adum = ad; bdum = bd; hia = ha; hib = hb; valid = 1'b1;
    e = model(o, x, cc, ci, av, bv, ad, bd, ha, hb);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      a = 16'hDEAD; b = 16'hBEEF; op = 3'b110;
    end
  endtask

  // monitor: scoreboard pop and compare
  logic [15:0] last_res;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      if (valid_o) begin
        if (sb_q.size() == 0) begin
          check("R11", "unexpected valid", 16'd1, 16'd0);
        end else begin
          e = sb_q.pop_front();
          check(e.tag, "result", result_o, e.res);
          check(e.tag, "carry", 16'(carry_o), 16'(e.c));
          check({e.tag, "/R10"}, "lt", 16'(lt_o), 16'(e.lt));
          check({e.tag, "/R10"}, "le", 16'(le_o), 16'(e.le));
          last_res = result_o;
        end
      end else if (checks > 5) begin
        check("R11", "hold", result_o, last_res);
      end
    end
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset valid", 16'(valid_o), 16'd0);
    check("R11", "reset result", result_o, 16'h0000);
    check("R11", "reset carry", 16'(carry_o), 16'd0);
    check("R11", "reset flags", {14'd0, lt_o, le_o}, 16'd0);
    rst_n = 1'b1;
    idle(2);

    // R1 logic ops
    drive("R1", 3'b000, 1'b0, 2'b00, 1'b1, 16'h005A, 16'h000F);
    drive("R1", 3'b001, 1'b1, 2'b00, 1'b0, 16'h1234, 16'hFF00);
    drive("R1", 3'b010, 1'b1, 2'b11, 1'b0, 16'hF0F0, 16'h3C3C);
    // R2 carry presets
    drive("R2", 3'b110, 1'b0, 2'b10, 1'b1, 16'h0001, 16'h0001);
    drive("R2", 3'b110, 1'b0, 2'b11, 1'b0, 16'h0001, 16'h0001);
    drive("R2", 3'b110, 1'b0, 2'b01, 1'b1, 16'h0001, 16'h0001);
    drive("R2", 3'b000, 1'b0, 2'b10, 1'b1, 16'h0001, 16'h0001);
    idle(2);
    // R3 / R4 binary
    drive("R3", 3'b110, 1'b0, 2'b00, 1'b0, 16'h00FF, 16'h0001);
    drive("R4", 3'b011, 1'b0, 2'b11, 1'b0, 16'h0005, 16'h0003);
    drive("R4", 3'b011, 1'b0, 2'b11, 1'b0, 16'h0003, 16'h0005);
    drive("R4", 3'b011, 1'b0, 2'b10, 1'b1, 16'h0005, 16'h0003);
    // R5 / R6 decimal
    drive("R5", 3'b100, 1'b0, 2'b10, 1'b0, 16'h0045, 16'h0038);
    drive("R5", 3'b100, 1'b0, 2'b10, 1'b0, 16'h0099, 16'h0001);
    drive("R6", 3'b101, 1'b0, 2'b11, 1'b0, 16'h0042, 16'h0017);
    drive("R6", 3'b101, 1'b0, 2'b11, 1'b0, 16'h0010, 16'h0020);
    idle(1);
    // R7 width behaviour
    drive("R7", 3'b110, 1'b1, 2'b10, 1'b0, 16'h00FF, 16'h0001);
    drive("R7", 3'b110, 1'b1, 2'b11, 1'b0, 16'h0000, 16'h0000);
    drive("R7", 3'b110, 1'b0, 2'b00, 1'b0, 16'hAB10, 16'hCD20);
    drive("R7", 3'b100, 1'b1, 2'b10, 1'b0, 16'h0999, 16'h0001);
    drive("R7", 3'b011, 1'b1, 2'b11, 1'b0, 16'h0100, 16'h0001);
    // R8 multiply
    drive("R8", 3'b111, 1'b0, 2'b00, 1'b1, 16'h00F3, 16'h005E, 1'b0, 1'b0, 1'b0, 1'b0);
    drive("R8", 3'b111, 1'b1, 2'b10, 1'b1, 16'h77F3, 16'h665E, 1'b0, 1'b0, 1'b1, 1'b1);
    drive("R8", 3'b111, 1'b0, 2'b11, 1'b0, 16'h00F3, 16'h005E, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9 dummy selects
    drive("R9", 3'b011, 1'b0, 2'b11, 1'b0, 16'h0055, 16'h0001, 1'b1, 1'b0);
    drive("R9", 3'b000, 1'b1, 2'b00, 1'b0, 16'h1234, 16'h5678, 1'b1, 1'b1);
    drive("R9", 3'b110, 1'b1, 2'b10, 1'b0, 16'h1234, 16'h5678, 1'b0, 1'b1);
    // R10 full-width compares
    drive("R10", 3'b000, 1'b1, 2'b00, 1'b0, 16'h0100, 16'h00FF);
    drive("R10", 3'b000, 1'b0, 2'b00, 1'b0, 16'h0100, 16'h00FF);
    drive("R10", 3'b011, 1'b1, 2'b11, 1'b0, 16'h4242, 16'h4242);
    drive("R10", 3'b111, 1'b1, 2'b00, 1'b0, 16'h0001, 16'h8000);
    idle(3);

    // mixed sweep
    for (int i = 0; i < 200; i++) begin
      logic [2:0]  ro = 3'($urandom);
      logic        rx = 1'($urandom);
      logic [15:0] ra = 16'($urandom);
      logic [15:0] rb = 16'($urandom);
      if (ro == 3'b100 || ro == 3'b101) begin
        for (int d = 0; d < 4; d++) begin
          ra[4*d +: 4] = 4'($urandom % 10);
          rb[4*d +: 4] = 4'($urandom % 10);
        end
      end
      drive(op_tag(ro), ro, rx, 2'($urandom), 1'($urandom), ra, rb,
            1'($urandom % 8 == 0), 1'($urandom % 8 == 0), 1'($urandom), 1'($urandom));
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    check("R11", "scoreboard drained", 16'(sb_q.size()), 16'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule